// File: doc/BRIEF.md
# Alternate-Master Bus Acquisition Handshake

This block is the control state machine of a secondary bus master, such as a DMA engine, that shares a system bus with a primary processor. The shared bus uses three wires for ownership: request, grant and grant-acknowledge, all active low. When the datapath raises its "need bus" input, the block asserts request and waits for grant. Once grant is seen, it waits until the bus cycle already in progress has finished. It then claims the bus by asserting acknowledge and drops request in the same clock.

Ownership is held through the acknowledge line only. The `owns_o` output gates the master's own bus drivers. When the datapath reports that its transfers are done, the block negates acknowledge. It then stays quiet for at least one clock, and for as long as grant remains asserted, before it may request again.

Grant, address strobe and the cycle-termination acknowledges arrive asynchronously, so each passes through a two-flop synchroniser. The shared lines are modelled as open-drain pins: a pin value plus an output enable that is high only while the line is pulled low.

Top module: `busreq_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle after that edge. In idle, `br_oe_o`=0, `ack_oe_o`=0, `br_n_o`=1, `ack_n_o`=1 and `owns_o`=0.
- R2: From idle, `need_i`=1 at a clock edge asserts request after that edge. Request asserted means `br_oe_o`=1 and `br_n_o`=0. Acknowledge asserted means `ack_oe_o`=1 and `ack_n_o`=0.
- R3: `bg_n_i`, `as_n_i` and every bit of `term_n_i` are seen only through two synchroniser flops. A change applied before edge k influences the state machine's decision at edge k+2, which is visible after that edge.
- R4: After grant is seen, acknowledge stays negated while the synchronised address strobe is low or any synchronised termination bit is low.
- R5: Acknowledge is asserted one edge after a sample that shows grant low, address strobe high and all termination bits high. Request is negated in the same cycle that acknowledge is asserted.
- R6: `owns_o` is 1 exactly while acknowledge is asserted. Once asserted, ownership is kept regardless of `need_i` and `bg_n_i` until `done_i` is seen.
- R7: `done_i`=1 at an edge while the block owns the bus negates acknowledge and `owns_o` after that edge.
- R8: If `need_i` is 0 at an edge while request is asserted, request is negated after that edge and no acknowledge is asserted.
- R9: After release, request stays negated for at least one clock. It also stays negated until grant has been sampled negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| need_i | input | 1 | Datapath wants the bus (synchronous) |
| done_i | input | 1 | Datapath finished its transfers (synchronous) |
| bg_n_i | input | 1 | Bus grant, active low, asynchronous |
| as_n_i | input | 1 | Address strobe of the current cycle, active low, asynchronous |
| term_n_i | input | TERM_W | Cycle-termination acknowledges, active low, asynchronous |
| br_n_o | output | 1 | Bus request pin value, active low |
| br_oe_o | output | 1 | Enable for the request driver |
| ack_n_o | output | 1 | Grant-acknowledge pin value, active low |
| ack_oe_o | output | 1 | Enable for the acknowledge driver |
| owns_o | output | 1 | Master drivers may drive the bus |

## Verification
The assertions assume that `need_i` and `done_i` are stable around the clock edge, because they come from the master's own clock domain. The bench therefore changes every input a quarter period after an edge. It also holds the asynchronous lines steady for at least two clocks, so that each value settles through both synchroniser flops. The checks also assume that the arbiter withdraws grant only after acknowledge, or before it. The stimulus never pulses grant shorter than the synchroniser delay.

// File: rtl/busreq_pkg.sv
// Package: shared types of the bus acquisition handshake.
// Assumes: nothing; pure type definitions.
package busreq_pkg;
    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,  // no request outstanding
        ST_REQ     = 3'd1,  // request asserted, grant not yet seen
        ST_WAITCYC = 3'd2,  // grant seen, waiting for current cycle to end
        ST_OWN     = 3'd3,  // acknowledge held, bus owned
        ST_RECOVER = 3'd4   // released, cooling down before next request
    } state_t;
endpackage

// File: rtl/busreq_sync.sv
// Module: multi-bit synchroniser chain for asynchronous inputs.
// Each bit passes through STAGES flops independently.
// Assumes: inputs are level signals that hold longer than STAGES clocks;
// reset value is given per bit by RST_VAL (negated level for active-low lines).
module busreq_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    // Shift each bit through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_o = chain[LAST];
endmodule

// File: rtl/busreq_fsm.sv
// Module: request / grant / acknowledge state machine of an alternate master.
// Consumes already-synchronised grant and bus-idle indications and produces
// the active-low open-drain style request and acknowledge lines.
// Assumes: need_i and done_i are synchronous to clk; gnt_s and bus_idle_s
// come from synchronisers.
module busreq_fsm
    import busreq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic need_i,
    input  logic done_i,
    input  logic gnt_s,       // grant asserted (synchronised, active high)
    input  logic bus_idle_s,  // no bus cycle in progress (synchronised)
    output logic br_n_o,
    output logic br_oe_o,
    output logic ack_n_o,
    output logic ack_oe_o,
    output logic owns_o
);
    state_t state_q, state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (need_i) state_d = ST_REQ;
            ST_REQ: begin
                if (!need_i)    state_d = ST_IDLE;
                else if (gnt_s) state_d = ST_WAITCYC;
            end
            ST_WAITCYC: begin
                if (!need_i)         state_d = ST_IDLE;
                else if (!gnt_s)     state_d = ST_REQ;
                else if (bus_idle_s) state_d = ST_OWN;
            end
            ST_OWN:     if (done_i) state_d = ST_RECOVER;
            ST_RECOVER: if (!gnt_s) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode: drive lines low only while asserted
    always_comb begin
        br_oe_o  = (state_q == ST_REQ) || (state_q == ST_WAITCYC);
        ack_oe_o = (state_q == ST_OWN);
        br_n_o   = !br_oe_o;
        ack_n_o  = !ack_oe_o;
        owns_o   = (state_q == ST_OWN);
    end

    // R5: request and acknowledge never asserted together
    a_r5_no_req_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_oe_o |-> !br_oe_o);

    // R4: acknowledge rises only after a sample of grant with an idle bus
    a_r4_ack_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_oe_o) |-> ($past(gnt_s) && $past(bus_idle_s)));

    // R7: done while owning releases acknowledge
    a_r7_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe_o && done_i) |=> !ack_oe_o);

    // R8: loss of need withdraws request with no acknowledge
    a_r8_abort_request: assert property (@(posedge clk) disable iff (!rst_n)
        (br_oe_o && !need_i) |=> (!br_oe_o && !ack_oe_o));

    // R9: at least one quiet clock after release
    a_r9_quiet_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_oe_o) |-> !br_oe_o);

    // R9: request can only start from idle, never straight from release
    a_r9_no_req_while_granted: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(br_oe_o) && !$past(ack_oe_o)) |-> $past(!gnt_s || state_q == ST_IDLE));

    // R6: ownership flag tracks acknowledge
    a_r6_owns_is_ack: assert property (@(posedge clk) disable iff (!rst_n)
        owns_o == ack_oe_o);
endmodule

// File: rtl/busreq_master.sv
// Module: top of the alternate-master bus acquisition handshake.
// Synchronises the asynchronous bus lines, derives bus-cycle completion and
// runs the request/grant/acknowledge controller.
// Assumes: TERM_W termination lines, all active low; synchronous reset.
module busreq_master #(
    parameter int TERM_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              need_i,
    input  logic              done_i,
    input  logic              bg_n_i,
    input  logic              as_n_i,
    input  logic [TERM_W-1:0] term_n_i,
    output logic              br_n_o,
    output logic              br_oe_o,
    output logic              ack_n_o,
    output logic              ack_oe_o,
    output logic              owns_o
);
    localparam int SW = TERM_W + 2;

    logic [SW-1:0] raw, synced;
    logic          gnt_s, bus_idle_s;

    assign raw = {term_n_i, as_n_i, bg_n_i};

    busreq_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    // Decode synchronised lines: grant active low, bus idle when all negated
    always_comb begin
        gnt_s      = !synced[0];
        bus_idle_s = &synced[SW-1:1];
    end

    busreq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .need_i     (need_i),
        .done_i     (done_i),
        .gnt_s      (gnt_s),
        .bus_idle_s (bus_idle_s),
        .br_n_o     (br_n_o),
        .br_oe_o    (br_oe_o),
        .ack_n_o    (ack_n_o),
        .ack_oe_o   (ack_oe_o),
        .owns_o     (owns_o)
    );
endmodule

// File: tb/sim_busreq_master.sv
// Bench: vector table walk then directed reset checks.
module sim_busreq_master;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 34;
    localparam int WATCHDOG = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       need_i = 1'b0, done_i = 1'b0, bg_n_i = 1'b1, as_n_i = 1'b1;
    logic [1:0] term_n_i = 2'b11;
    logic       br_n_o, br_oe_o, ack_n_o, ack_oe_o, owns_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busreq_master #(.TERM_W(2), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .need_i(need_i), .done_i(done_i),
        .bg_n_i(bg_n_i), .as_n_i(as_n_i), .term_n_i(term_n_i),
        .br_n_o(br_n_o), .br_oe_o(br_oe_o), .ack_n_o(ack_n_o),
        .ack_oe_o(ack_oe_o), .owns_o(owns_o)
    );

    // Row: {need, done, bg_n, as_n, term[1:0], exp_req, exp_ack, exp_own}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b1_0_1_1_11_1_0_0,  // 0  R2 request from idle
        9'b1_0_0_0_11_1_0_0,  // 1  grant + busy, sync stage 1
        9'b1_0_0_0_11_1_0_0,  // 2  R3 sync stage 2
        9'b1_0_0_0_11_1_0_0,  // 3  grant seen, waiting
        9'b1_0_0_0_11_1_0_0,  // 4  R4 strobe low holds off
        9'b1_0_0_1_11_1_0_0,  // 5  strobe released
        9'b1_0_0_1_11_1_0_0,  // 6  R3 still in synchroniser
        9'b1_0_0_1_11_0_1_1,  // 7  R5 acknowledge, request dropped
        9'b1_0_1_1_11_0_1_1,  // 8  R6 grant removed, still owner
        9'b1_1_1_1_11_0_0_0,  // 9  R7 release
        9'b1_0_1_1_11_0_0_0,  // 10 R9 quiet clock
        9'b1_0_1_1_11_1_0_0,  // 11 request again
        9'b0_0_1_1_11_0_0_0,  // 12 R8 abort before grant
        9'b1_0_1_1_11_1_0_0,  // 13 request
        9'b1_0_0_1_10_1_0_0,  // 14 grant, one termination low
        9'b1_0_0_1_10_1_0_0,  // 15
        9'b1_0_0_1_10_1_0_0,  // 16 waiting
        9'b1_0_0_1_11_1_0_0,  // 17 R4 termination released
        9'b1_0_0_1_11_1_0_0,  // 18
        9'b1_0_0_1_11_0_1_1,  // 19 R5 own
        9'b0_0_0_1_11_0_1_1,  // 20 R6 need gone, still owner
        9'b0_1_0_1_11_0_0_0,  // 21 R7 release
        9'b1_0_0_1_11_0_0_0,  // 22 R9 grant still low, no request
        9'b1_0_1_1_11_0_0_0,  // 23 grant negated, syncing
        9'b1_0_1_1_11_0_0_0,  // 24
        9'b1_0_1_1_11_0_0_0,  // 25 back to idle
        9'b1_0_1_1_11_1_0_0,  // 26 R9 request after grant negated
        9'b0_0_1_1_11_0_0_0,  // 27 R8 abort
        9'b1_0_1_1_11_1_0_0,  // 28 request
        9'b1_0_0_0_11_1_0_0,  // 29 grant, busy
        9'b1_0_0_0_11_1_0_0,  // 30
        9'b1_0_0_0_11_1_0_0,  // 31 waiting on strobe
        9'b0_0_0_0_11_0_0_0,  // 32 R8 abort after grant, no ack
        9'b0_0_1_1_11_0_0_0   // 33 idle
    };

    task automatic check_out(input string req, input logic er, input logic ea,
                             input logic eo);
        checks++;
        if (br_oe_o !== er || br_n_o !== !er || ack_oe_o !== ea ||
            ack_n_o !== !ea || owns_o !== eo) begin
            fails++;
            $display("FAIL %s t=%0t actual req/ack/own=%b%b%b pins br_n/ack_n=%b%b expected %b%b%b",
                     req, $time, br_oe_o, ack_oe_o, owns_o, br_n_o, ack_n_o, er, ea, eo);
        end
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check_out("R1", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            {need_i, done_i, bg_n_i, as_n_i, term_n_i} = VEC[i][8:3];
            @(posedge clk);
            #(CLK_PERIOD/4);
            check_out($sformatf("row%0d R2..R9", i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R6 directed: gain ownership with an idle bus
        need_i = 1'b1; bg_n_i = 1'b0; as_n_i = 1'b1; term_n_i = 2'b11; done_i = 1'b0;
        repeat (5) @(posedge clk);
        #(CLK_PERIOD/4);
        check_out("R6", 1'b0, 1'b1, 1'b1);

        // R1 directed: synchronous reset while owning
        rst_n = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check_out("R1", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        need_i = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check_out("R1", 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule